// File: doc/BRIEF.md
# Raster-Op and Alpha Blend Pixel Unit

This unit is the per-pixel arithmetic core of a two-dimensional block transfer engine. Each input beat carries one source pixel, one destination pixel, a write mask and the operation controls. Pixels are 32-bit ARGB words: the alpha byte is bits 31:24, and the three colour channels are bits 23:16, 15:8 and 7:0. The unit first combines the source and destination colour bits with a 4-bit logical raster operation. It then picks the output alpha and blends each colour channel with one of four equations. Last, it merges the result into the old destination under the write mask.

Beats enter and leave on a valid/ready stream, one pixel per cycle. The unit has three register stages, and each stage holds its contents while the stage after it is full and cannot move. The address walker and the memory port that feed it are separate blocks.

Top module: `pix_rop_blend`

## Requirements
- R1: For each colour bit, the raster result is bit `in_rop[{d,s}]`, where d is the destination bit and s the source bit. So 0000 gives zero, 1111 one, 1010 source, 1100 destination, 0110 XOR, 1001 XNOR, 0011 NOT destination, 0101 NOT source, 0010 NOT destination AND source, 0100 destination AND NOT source, 1000 AND and 1110 OR. The raster result (call it r) replaces the source colour in every blend below.
- R2: The output alpha byte comes from `in_asel`. 00 and 10 give the destination alpha (da), and 01 gives the source alpha (sa). 11 gives floor(sa*da/256)+1, or 0 when sa and da are both 0.
- R3: Blend mode 00 (`in_bmode`) outputs r on every colour channel.
- R4: In blend mode 01, a channel outputs d when sa is 0. Otherwise it outputs floor(((sa+1)*r + (255-sa)*d)/256).
- R5: In blend mode 10, a channel outputs r when da is 0. Otherwise it outputs floor(((255-da)*r + (da+1)*d)/256).
- R6: In blend mode 11, each side contributes 0 when its alpha is 0, pixel*256 when its alpha is 255, and otherwise pixel*(alpha+1). The channel outputs the sum of the two contributions divided by 256 and rounded down, limited to 255.
- R7: The output word is (blended word AND `in_mask`) OR (old destination AND NOT `in_mask`), over all 32 bits including alpha.
- R8: With `out_ready` held high, `in_ready` is high. A beat accepted at one clock edge shows on `out_valid`/`out_pix` after the third edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` does not change. No accepted beat is dropped, duplicated or reordered.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit accepts the input beat this cycle |
| in_src | input | 32 | Source ARGB pixel |
| in_dst | input | 32 | Old destination ARGB pixel |
| in_rop | input | 4 | Raster operation truth table |
| in_asel | input | 2 | Output alpha select |
| in_bmode | input | 2 | Blend equation select |
| in_mask | input | 32 | Destination write mask |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_pix | output | 32 | Result ARGB pixel |

## Verification
The assertions assume the consumer follows the stream rule: a beat counts as taken only in a cycle where `out_valid` and `out_ready` are both high. They also assume the producer counts a beat as given only in a cycle where `in_valid` and `in_ready` are both high. Under that rule, no more than three beats can be in flight. The stimulus keeps within it by sampling `in_ready` and `out_valid` between clock edges and logging a beat only when both sides of a handshake are high. The stimulus mixes directed corner beats with random beats from a fixed seed. The directed beats cover all sixteen raster codes, alphas of 0 and 255, saturating sums and partial masks. Random stalls on `out_ready` exercise the hold behaviour.

// File: rtl/pix_rb_pkg.sv
package pix_rb_pkg;

  typedef enum logic [1:0] {
    ASEL_KEEP = 2'b00,
    ASEL_SRC  = 2'b01,
    ASEL_DST  = 2'b10,
    ASEL_PROD = 2'b11
  } asel_e;

  typedef enum logic [1:0] {
    BM_COPY  = 2'b00,
    BM_SRC_W = 2'b01,
    BM_DST_W = 2'b10,
    BM_SUM   = 2'b11
  } bmode_e;

  typedef struct packed {
    asel_e  asel;
    bmode_e bmode;
  } mode_t;

endpackage

// File: rtl/pix_rb_rop.sv
module pix_rb_rop
  import pix_rb_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      in_v,
  input  logic [CH_W*(NCH+1)-1:0]   src,
  input  logic [CH_W*(NCH+1)-1:0]   dst,
  input  logic [CH_W*(NCH+1)-1:0]   mask,
  input  logic [3:0]                rop,
  input  mode_t                     mode,
  output logic                      q_v,
  output logic [CH_W*NCH-1:0]       q_col,
  output logic [CH_W-1:0]           q_sa,
  output logic [CH_W-1:0]           q_da,
  output logic [CH_W*(NCH+1)-1:0]   q_dst,
  output logic [CH_W*(NCH+1)-1:0]   q_mask,
  output mode_t                     q_mode
);

  localparam int CW = CH_W * NCH;
  localparam int PW = CW + CH_W;

  logic [CW-1:0] col_d;

  genvar gb;
  generate
    for (gb = 0; gb < CW; gb++) begin : g_bit
      always_comb col_d[gb] = rop[{dst[gb], src[gb]}];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_v <= 1'b0;
    else if (en) q_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_col  <= col_d;
      q_sa   <= src[PW-1 -: CH_W];
      q_da   <= dst[PW-1 -: CH_W];
      q_dst  <= dst;
      q_mask <= mask;
      q_mode <= mode;
    end
  end

  // R1: pass-source code forwards the source colour one cycle later
  p_rop_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && rop == 4'b1010) |=> (q_v && q_col == $past(src[CW-1:0])));

  // R1: XOR code against the registered operands
  p_rop_xor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && rop == 4'b0110) |=> (q_col == ($past(src[CW-1:0]) ^ $past(dst[CW-1:0]))));

endmodule

// File: rtl/pix_rb_blend.sv
module pix_rb_blend
  import pix_rb_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      in_v,
  input  logic [CH_W*NCH-1:0]       col,
  input  logic [CH_W-1:0]           sa,
  input  logic [CH_W-1:0]           da,
  input  logic [CH_W*(NCH+1)-1:0]   dst,
  input  logic [CH_W*(NCH+1)-1:0]   mask,
  input  mode_t                     mode,
  output logic                      q_v,
  output logic [CH_W*(NCH+1)-1:0]   q_pix,
  output logic [CH_W*(NCH+1)-1:0]   q_dst,
  output logic [CH_W*(NCH+1)-1:0]   q_mask
);

  localparam int CW = CH_W * NCH;
  localparam int PW = CW + CH_W;
  localparam int SW = 2 * CH_W + 2;
  localparam logic [SW-1:0] MAXV = SW'((1 << CH_W) - 1);
  localparam logic [CH_W-1:0] AMAX = CH_W'((1 << CH_W) - 1);

  function automatic logic [SW-1:0] weigh(input logic [CH_W-1:0] p,
                                          input logic [CH_W-1:0] a);
    logic [SW-1:0] t;
    if (a == '0)        t = '0;
    else if (a == AMAX) t = SW'(p) << CH_W;
    else                t = SW'(p) * (SW'(a) + SW'(1));
    return t;
  endfunction

  function automatic logic [CH_W-1:0] clip(input logic [SW-1:0] sum);
    logic [SW-1:0] q;
    q = sum >> CH_W;
    return (q > MAXV) ? AMAX : q[CH_W-1:0];
  endfunction

  function automatic logic [CH_W-1:0] mix(input bmode_e m,
                                          input logic [CH_W-1:0] s,
                                          input logic [CH_W-1:0] d,
                                          input logic [CH_W-1:0] a_s,
                                          input logic [CH_W-1:0] a_d);
    logic [SW-1:0] sum;
    logic [CH_W-1:0] r;
    case (m)
      BM_COPY: r = s;
      BM_SRC_W: begin
        sum = (SW'(a_s) + SW'(1)) * SW'(s) + (MAXV - SW'(a_s)) * SW'(d);
        r   = (a_s == '0) ? d : clip(sum);
      end
      BM_DST_W: begin
        sum = (MAXV - SW'(a_d)) * SW'(s) + (SW'(a_d) + SW'(1)) * SW'(d);
        r   = (a_d == '0) ? s : clip(sum);
      end
      default: r = clip(weigh(s, a_s) + weigh(d, a_d));
    endcase
    return r;
  endfunction

  logic [CW-1:0]   col_d;
  logic [CH_W-1:0] alpha_d;
  logic [SW-1:0]   aprod;

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      always_comb col_d[gc*CH_W +: CH_W] =
        mix(mode.bmode, col[gc*CH_W +: CH_W], dst[gc*CH_W +: CH_W], sa, da);
    end
  endgenerate

  always_comb begin
    aprod = SW'(sa) * SW'(da);
    case (mode.asel)
      ASEL_SRC:  alpha_d = sa;
      ASEL_PROD: alpha_d = (sa == '0 && da == '0) ? '0
                           : CH_W'((aprod >> CH_W) + SW'(1));
      default:   alpha_d = da;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_v <= 1'b0;
    else if (en) q_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      q_pix  <= {alpha_d, col_d};
      q_dst  <= dst;
      q_mask <= mask;
    end
  end

  // R3: copy mode leaves the raster colour untouched
  p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && mode.bmode == BM_COPY) |=> (q_pix[CW-1:0] == $past(col)));

  // R2: source-alpha select carries sa through
  p_asel_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && mode.asel == ASEL_SRC) |=> (q_pix[PW-1 -: CH_W] == $past(sa)));

  // R4: zero source alpha in mode 01 yields the destination colour
  p_srcw_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && mode.bmode == BM_SRC_W && sa == '0)
      |=> (q_pix[CW-1:0] == $past(dst[CW-1:0])));

  // R5: zero destination alpha in mode 10 yields the raster colour
  p_dstw_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && mode.bmode == BM_DST_W && da == '0)
      |=> (q_pix[CW-1:0] == $past(col)));

endmodule

// File: rtl/pix_rb_merge.sv
module pix_rb_merge #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_v,
  input  logic [PW-1:0] pix,
  input  logic [PW-1:0] dst,
  input  logic [PW-1:0] mask,
  output logic          q_v,
  output logic [PW-1:0] q_pix
);

  logic [PW-1:0] pix_d;

  always_comb pix_d = (pix & mask) | (dst & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_v <= 1'b0;
    else if (en) q_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) q_pix <= pix_d;
  end

  // R7: an all-zero mask writes back the old destination
  p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && mask == '0) |=> (q_pix == $past(dst)));

  // R7: an all-ones mask writes the blended word
  p_mask_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_v && mask == '1) |=> (q_pix == $past(pix)));

endmodule

// File: rtl/pix_rop_blend.sv
module pix_rop_blend
  import pix_rb_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CH_W*(NCH+1)-1:0] in_src,
  input  logic [CH_W*(NCH+1)-1:0] in_dst,
  input  logic [3:0]              in_rop,
  input  logic [1:0]              in_asel,
  input  logic [1:0]              in_bmode,
  input  logic [CH_W*(NCH+1)-1:0] in_mask,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CH_W*(NCH+1)-1:0] out_pix
);

  localparam int CW    = CH_W * NCH;
  localparam int PW    = CW + CH_W;
  localparam int DEPTH = 3;
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // stage enables: a stage moves when it is empty or its successor moves
  logic en1, en2, en3;
  logic v1, v2, v3;

  always_comb begin
    en3 = !v3 || out_ready;
    en2 = !v2 || en3;
    en1 = !v1 || en2;
  end

  assign in_ready  = en1;
  assign out_valid = v3;

  mode_t mode_in;
  always_comb begin
    mode_in.asel  = asel_e'(in_asel);
    mode_in.bmode = bmode_e'(in_bmode);
  end

  logic [CW-1:0]   s1_col;
  logic [CH_W-1:0] s1_sa, s1_da;
  logic [PW-1:0]   s1_dst, s1_mask;
  mode_t           s1_mode;

  pix_rb_rop #(.CH_W(CH_W), .NCH(NCH)) i_rop (
    .clk    (clk),
    .rst_n  (rst_ni),
    .en     (en1),
    .in_v   (in_valid),
    .src    (in_src),
    .dst    (in_dst),
    .mask   (in_mask),
    .rop    (in_rop),
    .mode   (mode_in),
    .q_v    (v1),
    .q_col  (s1_col),
    .q_sa   (s1_sa),
    .q_da   (s1_da),
    .q_dst  (s1_dst),
    .q_mask (s1_mask),
    .q_mode (s1_mode)
  );

  logic [PW-1:0] s2_pix, s2_dst, s2_mask;

  pix_rb_blend #(.CH_W(CH_W), .NCH(NCH)) i_blend (
    .clk    (clk),
    .rst_n  (rst_ni),
    .en     (en2),
    .in_v   (v1),
    .col    (s1_col),
    .sa     (s1_sa),
    .da     (s1_da),
    .dst    (s1_dst),
    .mask   (s1_mask),
    .mode   (s1_mode),
    .q_v    (v2),
    .q_pix  (s2_pix),
    .q_dst  (s2_dst),
    .q_mask (s2_mask)
  );

  pix_rb_merge #(.PW(PW)) i_merge (
    .clk   (clk),
    .rst_n (rst_ni),
    .en    (en3),
    .in_v  (v2),
    .pix   (s2_pix),
    .dst   (s2_dst),
    .mask  (s2_mask),
    .q_v   (v3),
    .q_pix (out_pix)
  );

  // in-flight beat count, kept for the checks below
  logic [OCC_W-1:0] occ_q, occ_d;
  logic acc, ret;

  always_comb begin
    acc   = in_valid && in_ready;
    ret   = out_valid && out_ready;
    occ_d = occ_q + OCC_W'(acc) - OCC_W'(ret);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_d;
  end

  // R9: no more beats in flight than register stages
  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    occ_q <= OCC_W'(DEPTH));

  // R9: a stalled output holds its word
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R9: an output beat exists only if a beat was accepted earlier
  p_no_phantom_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (occ_q != '0));

  // R8: a free-running consumer never throttles the producer
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_ready |-> in_ready);

endmodule

// File: tb/test_pix_rop_blend.sv
module test_pix_rop_blend;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_src, in_dst, in_mask;
  logic [3:0]  in_rop;
  logic [1:0]  in_asel, in_bmode;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_pix;

  pix_rop_blend i_pix_rop_blend (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_src    (in_src),
    .in_dst    (in_dst),
    .in_rop    (in_rop),
    .in_asel   (in_asel),
    .in_bmode  (in_bmode),
    .in_mask   (in_mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int n_in   = 0;
  int n_out  = 0;
  bit rdy_rand = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference: minterm sum of the raster code, then blend, then mask
  function automatic int weight(input int p, input int a);
    if (a == 0) return 0;
    if (a == 255) return p * 256;
    return p * (a + 1);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] d,
                                        input logic [3:0] rop, input logic [1:0] asel,
                                        input logic [1:0] bm, input logic [31:0] m);
    logic [23:0] r;
    logic [31:0] w;
    int sa, da, rc, dc, v, al;
    sa = int'(s[31:24]);
    da = int'(d[31:24]);
    r = ({24{rop[0]}} & ~d[23:0] & ~s[23:0]) | ({24{rop[1]}} & ~d[23:0] & s[23:0]) |
        ({24{rop[2]}} & d[23:0] & ~s[23:0]) | ({24{rop[3]}} & d[23:0] & s[23:0]);
    for (int c = 0; c < 3; c++) begin
      rc = int'(r[c*8 +: 8]);
      dc = int'(d[c*8 +: 8]);
      case (bm)
        2'b00: v = rc;
        2'b01: v = (sa == 0) ? dc : ((sa + 1) * rc + (255 - sa) * dc) / 256;
        2'b10: v = (da == 0) ? rc : ((255 - da) * rc + (da + 1) * dc) / 256;
        default: begin
          v = (weight(rc, sa) + weight(dc, da)) / 256;
          if (v > 255) v = 255;
        end
      endcase
      w[c*8 +: 8] = v[7:0];
    end
    case (asel)
      2'b01:   al = sa;
      2'b11:   al = (sa == 0 && da == 0) ? 0 : (sa * da) / 256 + 1;
      default: al = da;
    endcase
    w[31:24] = al[7:0];
    return (w & m) | (d & ~m);
  endfunction

  // driver: present one beat, keep it until accepted
  task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [3:0] rop,
                      input logic [1:0] asel, input logic [1:0] bm, input logic [31:0] m,
                      input string tag);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_src = s; in_dst = d; in_rop = rop;
      in_asel = asel; in_bmode = bm; in_mask = m;
      #3;
      if (in_ready) begin
        exp_q.push_back(model(s, d, rop, asel, bm, m));
        tag_q.push_back(tag);
        n_in++;
        done = 1'b1;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  // monitor: drives out_ready, checks every output beat and stall holds
  initial begin
    logic [31:0] held;
    bit          hold_pend;
    logic [31:0] e;
    string       t;
    hold_pend = 1'b0;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      #2;
      if (hold_pend)
        check(out_valid && out_pix == held, "R9 stall hold", out_pix, held);
      hold_pend = 1'b0;
      if (out_valid && !out_ready) begin
        held = out_pix;
        hold_pend = 1'b1;
      end
      if (out_valid && out_ready) begin
        n_out++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected beat", out_pix, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_pix == e, t, out_pix, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [31:0] cs, cd;

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_src = '0; in_dst = '0; in_mask = '0;
    in_rop = '0; in_asel = '0; in_bmode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    // R10: reset state
    check(out_valid == 1'b0, "R10 out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R10 in_ready after reset", {31'b0, in_ready}, 32'h1);

    // R8: three-cycle latency with the consumer always ready
    send(32'h11223344, 32'h55667788, 4'b1010, 2'b01, 2'b00, 32'hFFFFFFFF, "R8 value");
    check(in_ready == 1'b1, "R8 ready with out_ready high", {31'b0, in_ready}, 32'h1);
    @(negedge clk); in_valid = 1'b0; #3;
    check(out_valid == 1'b0, "R8 not valid after 1 edge", {31'b0, out_valid}, 32'h0);
    @(negedge clk); #3;
    check(out_valid == 1'b0, "R8 not valid after 2 edges", {31'b0, out_valid}, 32'h0);
    @(negedge clk); #3;
    check(out_valid == 1'b1, "R8 valid after 3 edges", {31'b0, out_valid}, 32'h1);
    drain();

    // R1: every raster code
    for (int k = 0; k < 16; k++)
      send(32'h80A53CF0, 32'h405AC30F, 4'(k), 2'b00, 2'b00, 32'hFFFFFFFF, "R1 raster code");
    idle(); drain();

    // R2: alpha selects, including both-zero product
    for (int k = 0; k < 4; k++)
      send(32'h80102030, 32'h40405060, 4'b1010, 2'(k), 2'b00, 32'hFFFFFFFF, "R2 alpha select");
    send(32'h00102030, 32'h00405060, 4'b1010, 2'b11, 2'b00, 32'hFFFFFFFF, "R2 both alphas zero");
    send(32'hFF102030, 32'hFF405060, 4'b1010, 2'b11, 2'b00, 32'hFFFFFFFF, "R2 both alphas full");
    send(32'h00102030, 32'h7F405060, 4'b1010, 2'b11, 2'b00, 32'hFFFFFFFF, "R2 one alpha zero");
    // R3: copy mode
    send(32'h33ABCDEF, 32'hCC123456, 4'b1010, 2'b00, 2'b00, 32'hFFFFFFFF, "R3 copy");
    send(32'h33ABCDEF, 32'hCC123456, 4'b1110, 2'b01, 2'b00, 32'hFFFFFFFF, "R3 copy of OR");
    // R4: source weighted
    send(32'h00FF8001, 32'h80102030, 4'b1010, 2'b00, 2'b01, 32'hFFFFFFFF, "R4 sa zero");
    send(32'hFFFF8001, 32'h80102030, 4'b1010, 2'b00, 2'b01, 32'hFFFFFFFF, "R4 sa full");
    send(32'h7FFF8001, 32'h80102030, 4'b1010, 2'b00, 2'b01, 32'hFFFFFFFF, "R4 sa mid");
    // R5: destination weighted
    send(32'h80FF8001, 32'h00102030, 4'b1010, 2'b00, 2'b10, 32'hFFFFFFFF, "R5 da zero");
    send(32'h80FF8001, 32'hFF102030, 4'b1010, 2'b00, 2'b10, 32'hFFFFFFFF, "R5 da full");
    send(32'h80FF8001, 32'h30102030, 4'b1010, 2'b00, 2'b10, 32'hFFFFFFFF, "R5 da mid");
    // R6: summed terms with saturation
    send(32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1010, 2'b00, 2'b11, 32'hFFFFFFFF, "R6 saturate");
    send(32'h00FFFFFF, 32'h00FFFFFF, 4'b1010, 2'b00, 2'b11, 32'hFFFFFFFF, "R6 both alphas zero");
    send(32'h40806040, 32'hC0204080, 4'b1010, 2'b00, 2'b11, 32'hFFFFFFFF, "R6 mid alphas");
    send(32'hFF806040, 32'h00204080, 4'b1010, 2'b00, 2'b11, 32'hFFFFFFFF, "R6 full and zero");
    // R7: write mask
    send(32'h12345678, 32'h9ABCDEF0, 4'b1010, 2'b01, 2'b00, 32'h00FF00F0, "R7 partial mask");
    send(32'h12345678, 32'h9ABCDEF0, 4'b1111, 2'b01, 2'b00, 32'h00000000, "R7 zero mask");
    send(32'h12345678, 32'h9ABCDEF0, 4'b0000, 2'b11, 2'b11, 32'hF0F0F0F0, "R7 mixed mask");
    idle(); drain();

    // R9: random traffic against random back-pressure
    rdy_rand = 1'b1;
    for (int k = 0; k < 400; k++) begin
      cs = $urandom;
      cd = $urandom;
      if (($urandom % 8) == 0) cs[31:24] = 8'h00;
      if (($urandom % 8) == 0) cd[31:24] = 8'hFF;
      send(cs, cd, 4'($urandom), 2'($urandom), 2'($urandom),
           (($urandom % 2) == 0) ? 32'hFFFFFFFF : $urandom, "R9 random beat");
      if (($urandom % 5) == 0) idle();
    end
    idle();
    rdy_rand = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && n_in == n_out, "R9 beat count", 32'(n_out), 32'(n_in));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule